// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a logical address onto a physical address through a small table of segments held in registers. The upper bits of the logical address choose a segment, and the lower bits give an offset into it. Each segment has a base, a bound, a write-enable flag, a shared flag and a valid flag. A request either comes back as the base plus the offset, or it comes back as a fault with a two-bit cause.

Software fills the table one entry at a time through a configuration write port. A single clear strobe empties the whole table, which is what happens when a new process context starts. The lookup is combinational from the registered table. The result is registered once, so every response comes out exactly one cycle after its request.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid and `rsp_valid` is 0. A request issued before any configuration write gets cause 11.
- R2: With the default parameters the logical address is 19 bits wide. Bits [18:16] select one of 8 segments, and bits [15:0] are the offset.
- R3: A request without a fault returns `rsp_paddr` = base + offset. The result is a 17-bit sum with no truncation, so the carry out of bit 15 appears in bit 16.
- R4: An offset strictly greater than the selected segment's bound gives cause 01. An offset equal to the bound is allowed.
- R5: A request to an invalid entry gives cause 11. This cause wins over every other fault, whatever the offset or the access type.
- R6: A write to a segment whose write-enable flag is 0 gives cause 10, and reads of that segment succeed. A request that breaks both the bound and the write rule reports cause 01.
- R7: Cause encoding: 00 none, 01 bounds, 10 protection, 11 not present. `rsp_fault` is 1 exactly when the cause is not 00. While faulting, `rsp_paddr` and `rsp_shared` are 0.
- R8: On success, `rsp_shared` returns the shared flag of the segment that was hit.
- R9: A configuration write fills all fields of the entry and marks it valid, starting from the next cycle. A request made in the same cycle as the write still sees the old entry.
- R10: `cfg_clear` invalidates every entry in one cycle. It takes priority over a configuration write in the same cycle.
- R11: `rsp_valid` follows `req_valid` with one cycle of delay. When no response is present, the cause is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 3 | Entry index for the write |
| cfg_base | input | 16 | Segment base |
| cfg_bound | input | 16 | Highest legal offset |
| cfg_wr_ok | input | 1 | 1 = writes allowed, 0 = read-only |
| cfg_shared | input | 1 | Shared flag |
| cfg_clear | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | 19 | Logical address {segment, offset} |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 2 | Fault cause |
| rsp_paddr | output | 17 | Physical address |
| rsp_shared | output | 1 | Shared flag of the segment that was hit |

## Verification
The table is loaded with five example segments and three empty slots. Every segment is then swept with offsets of zero, one, bound−1, bound, bound+1, the largest offset and a mid value, each with both a read and a write. These points separate the off-by-one edge of the bounds compare and the read-only segments, and the empty slots show that the not-present cause wins. A strided sweep across the whole offset space of one segment checks the adder on many operands. A wide base and a wide bound push the sum past 16 bits. Separate patterns issue a write and a request in the same cycle, and a clear together with a write, to fix when table changes become visible.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 3,
  parameter int OFF_BITS = 16,
  parameter int BASE_W   = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [SEG_BITS-1:0]                    cfg_idx,
  input  logic [BASE_W-1:0]                      cfg_base,
  input  logic [OFF_BITS-1:0]                    cfg_bound,
  input  logic                                   cfg_wr_ok,
  input  logic                                   cfg_shared,
  input  logic                                   cfg_clear,
  input  logic                                   req_valid,
  input  logic                                   req_write,
  input  logic [SEG_BITS+OFF_BITS-1:0]           req_addr,
  output logic                                   rsp_valid,
  output logic                                   rsp_fault,
  output logic [1:0]                             rsp_cause,
  output logic [((BASE_W > OFF_BITS) ? BASE_W : OFF_BITS):0] rsp_paddr,
  output logic                                   rsp_shared
);
  localparam int NSEG = 1 << SEG_BITS;
  localparam int LA_W = SEG_BITS + OFF_BITS;
  localparam int PA_W = ((BASE_W > OFF_BITS) ? BASE_W : OFF_BITS) + 1;

  localparam logic [1:0] C_NONE   = 2'b00;
  localparam logic [1:0] C_BOUNDS = 2'b01;
  localparam logic [1:0] C_PROT   = 2'b10;
  localparam logic [1:0] C_ABSENT = 2'b11;

  logic [BASE_W-1:0]   base_q  [NSEG];
  logic [OFF_BITS-1:0] bound_q [NSEG];
  logic [NSEG-1:0]     valid_q, wr_ok_q, shared_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= '0;
    else if (cfg_clear)
      valid_q <= '0;
    else if (cfg_we)
      valid_q[cfg_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_clear) begin
      base_q[cfg_idx]   <= cfg_base;
      bound_q[cfg_idx]  <= cfg_bound;
      wr_ok_q[cfg_idx]  <= cfg_wr_ok;
      shared_q[cfg_idx] <= cfg_shared;
    end
  end

  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic                over, deny;
  logic [1:0]          cause_d;
  logic [PA_W-1:0]     sum;

  assign seg  = req_addr[LA_W-1:OFF_BITS];
  assign off  = req_addr[OFF_BITS-1:0];
  assign over = off > bound_q[seg];
  assign deny = req_write && !wr_ok_q[seg];
  assign sum  = PA_W'(base_q[seg]) + PA_W'(off);

  assign cause_d = !valid_q[seg] ? C_ABSENT :
                   over          ? C_BOUNDS :
                   deny          ? C_PROT   : C_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_cause  <= C_NONE;
      rsp_paddr  <= '0;
      rsp_shared <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_cause  <= req_valid ? cause_d : C_NONE;
      rsp_paddr  <= (req_valid && cause_d == C_NONE) ? sum : '0;
      rsp_shared <= req_valid && cause_d == C_NONE && shared_q[seg];
    end
  end

  assign rsp_fault = rsp_cause != C_NONE;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_clear,
  input logic        req_valid,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [1:0]  rsp_cause,
  input logic [16:0] rsp_paddr,
  input logic        rsp_shared
);
  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_cause == 2'b00));
  // R7
  fault_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_shared));
  // R6
  prot_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 2'b10) |-> $past(req_write));
  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear ##1 req_valid |=> rsp_cause == 2'b11);
endmodule

bind seg_xlate seg_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .req_valid(req_valid),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_shared(rsp_shared)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_wr_ok = 1'b0, cfg_shared = 1'b0, cfg_clear = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0, cfg_bound = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic        rsp_valid, rsp_fault, rsp_shared;
  logic [1:0]  rsp_cause;
  logic [16:0] rsp_paddr;

  int vectors = 0, fails = 0;
  int m_base[8], m_bound[8];
  bit m_val[8], m_wr[8], m_shr[8];
  bit e_val, e_shr;
  int e_cause, e_pa;
  string e_tag;

  always #4 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_bound(cfg_bound), .cfg_wr_ok(cfg_wr_ok),
    .cfg_shared(cfg_shared), .cfg_clear(cfg_clear), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .rsp_shared(rsp_shared)
  );

  task automatic check();
    bit bad;
    vectors++;
    bad = (rsp_valid !== e_val) || (rsp_cause !== 2'(e_cause)) ||
          (rsp_fault !== (e_cause != 0)) || (rsp_paddr !== 17'(e_pa)) ||
          (rsp_shared !== e_shr);
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d pa=%h sh=%0b exp v=%0b f=%0b c=%0d pa=%h sh=%0b",
               e_tag, rsp_valid, rsp_fault, rsp_cause, rsp_paddr, rsp_shared,
               e_val, e_cause != 0, e_cause, e_pa, e_shr);
    end
  endtask

  function automatic void expect_for(int seg, int off, bit wr);
    e_val = 1'b1;
    if (!m_val[seg]) e_cause = 3;
    else if (off > m_bound[seg]) e_cause = 1;
    else if (wr && !m_wr[seg]) e_cause = 2;
    else e_cause = 0;
    e_pa  = (e_cause == 0) ? m_base[seg] + off : 0;
    e_shr = (e_cause == 0) ? m_shr[seg] : 1'b0;
  endfunction

  task automatic issue(int seg, int off, bit wr, string tag);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {3'(seg), 16'(off)};
    expect_for(seg, off, wr);
    e_tag = tag;
    @(negedge clk);
    check();
  endtask

  task automatic idle(string tag);
    req_valid = 1'b0;
    e_val = 0; e_cause = 0; e_pa = 0; e_shr = 0; e_tag = tag;
    @(negedge clk);
    check();
  endtask

  task automatic write_entry(int idx, int base, int bound, bit wr, bit shr);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = 16'(base); cfg_bound = 16'(bound);
    cfg_wr_ok = wr; cfg_shared = shr;
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[idx] = base; m_bound[idx] = bound; m_val[idx] = 1; m_wr[idx] = wr; m_shr[idx] = shr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    foreach (m_val[i]) begin m_val[i] = 0; m_base[i] = 0; m_bound[i] = 0; m_wr[i] = 0; m_shr[i] = 0; end
    repeat (3) @(negedge clk);
    e_val = 0; e_cause = 0; e_pa = 0; e_shr = 0; e_tag = "R1 reset outputs";
    check();
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, 0, 1'b0, "R1 empty table after reset");
    idle("R11 idle after request");

    write_entry(0, 'h1000, 'h1120, 1, 0);
    write_entry(1, 'h3000, 'h3340, 0, 1);
    write_entry(2, 'h0000, 'h0FFF, 1, 0);
    write_entry(3, 'h2000, 'h2F00, 1, 1);
    write_entry(4, 'h4000, 'h4520, 0, 0);

    // R2 R3 R4 R5 R6 R7 R8: segment/offset sweep with reads and writes
    for (int s = 0; s < 8; s++) begin
      int b = m_bound[s];
      int offs[7] = '{0, 1, 'h7FF, (b > 0) ? b - 1 : 0, b, (b < 'hFFFF) ? b + 1 : b, 'hFFFF};
      for (int k = 0; k < 7; k++)
        for (int w = 0; w < 2; w++)
          issue(s, offs[k], w[0], "R2/R3/R4/R5/R6/R7/R8 sweep");
    end
    idle("R11 idle after sweep");

    // R3: strided pass over the offset space of segment 3
    for (int o = 0; o < 'h10000; o += 257)
      issue(3, o, 1'b0, "R3 strided offsets");

    // R6: out of bounds write on read-only segment reports bounds
    issue(4, 'h4521, 1'b1, "R6 bounds before protection");
    // R5: invalid entry with out of range write reports not present
    issue(7, 'hFFFF, 1'b1, "R5 absent wins");

    // R3: carry into bit 16
    write_entry(2, 'hFFFF, 'hFFFF, 0, 1);
    issue(2, 'hFFFF, 1'b0, "R3 carry out");
    issue(2, 'h0001, 1'b1, "R6 read-only write");

    // R9: same-cycle write and request sees old entry
    cfg_we = 1'b1; cfg_idx = 3'd5; cfg_base = 16'h0800; cfg_bound = 16'h00FF;
    cfg_wr_ok = 1'b1; cfg_shared = 1'b1;
    issue(5, 'h10, 1'b0, "R9 request same cycle as write");
    cfg_we = 1'b0;
    m_base[5] = 'h0800; m_bound[5] = 'h00FF; m_val[5] = 1; m_wr[5] = 1; m_shr[5] = 1;
    issue(5, 'h10, 1'b1, "R9 entry usable next cycle");

    // R10: clear with simultaneous write, clear wins
    cfg_clear = 1'b1; cfg_we = 1'b1; cfg_idx = 3'd0; cfg_base = 16'h1234;
    cfg_bound = 16'hFFFF; cfg_wr_ok = 1'b1; cfg_shared = 1'b0;
    @(negedge clk);
    cfg_clear = 1'b0; cfg_we = 1'b0;
    foreach (m_val[i]) m_val[i] = 0;
    for (int s = 0; s < 8; s++)
      issue(s, 0, 1'b0, "R10 cleared table");
    idle("R11 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule